// File: doc/BRIEF.md
# Access Permission Checker with Fault Status

This block sits behind a page-table lookup. It takes the three-bit permission field of a translated page entry and the kind of access being made, and decides whether that access may proceed. A request is a single-cycle strobe carrying:

- the permission field;
- write, fetch and supervisor flags;
- the entry's modified bit;
- a no-fault mode bit;
- the virtual address.

One cycle later the block answers with a fault indication, a fault code, and the read, write and execute rights that a TLB may cache for the page.

Faults that are not suppressed are logged in two registers that software can read:

- **Status word.** It holds the access index, the fault code, an address-valid bit and an overflow bit. A fault that arrives while an earlier one is still unread sets the overflow bit.
- **Fault address.** It holds the virtual address of the faulting access.

Software signals that it has consumed the status with a read strobe, which empties the status word.

Top module: `access_guard`

## Requirements
- R1: The access index is {write, fetch, supervisor} (bit 2 = write, bit 1 = fetch, bit 0 = supervisor). A logged fault writes this index into status bits [7:5]. It ORs the fault code (8 or 12) into the low bits and sets bit 1 (address valid).
- R2: The fault code follows a fixed table indexed by access index and permission. Every listed row is given for permissions 0 to 7, where 0 means allowed, 8 a protection fault and 12 a privilege fault.
  - user read: 0,0,0,0,8,0,12,12
  - supervisor read: 0,0,0,0,8,0,0,0
  - user fetch: 8,8,0,0,0,8,12,12
  - supervisor fetch: 8,8,0,0,0,8,0,0
  - user write: 8,0,8,0,8,8,12,12
  - supervisor write: 8,0,8,0,8,0,8,0
  - user write+fetch: 8,8,8,0,8,8,12,12
  - supervisor write+fetch: 8,8,8,0,8,8,8,0
- R3: When a fault is logged while the status word is nonzero, the old contents are discarded and bit 0 (overflow) is set, together with the new fields of R1.
- R4: On a supervisor access that is not faulted, the rights {read, write, execute} for permissions 0 to 7 are R, RW, RX, RWX, X, RW, RX, RWX.
- R5: On a user access that is not faulted, the rights for permissions 0 to 4 match R4. Permission 5 grants R, and permissions 6 and 7 grant nothing.
- R6: The write right is granted only when the entry's modified bit is set.
- R7: With no-fault mode on, a user access that the table would fault reports no fault, logs nothing and receives the rights of R5. Supervisor accesses still fault.
- R8: A logged fault loads the fault address register with the request's virtual address.
- R9: A status read strobe with no fault in the same cycle clears the status word to zero on the next cycle. The fault address register is unchanged.
- R10: When a fault and a status read strobe occur in the same cycle, the fault is logged and the clear is ignored.
- R11: After reset the status word, fault address, response valid, fault flag, code and rights are all zero.
- R12: The response appears exactly one cycle after the request. On a reported fault, rsp_code carries the code, and all rights are zero. Otherwise rsp_code is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access check request strobe |
| perm | input | 3 | Page entry permission field |
| acc_write | input | 1 | Access is a write |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_super | input | 1 | Access is from supervisor mode |
| pg_modified | input | 1 | Entry's modified bit |
| nofault_en | input | 1 | No-fault mode |
| vaddr | input | AW | Virtual address of the access |
| stat_rd | input | 1 | Software read of status (clears it) |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_fault | output | 1 | Access faulted |
| rsp_code | output | 4 | Fault code: 0, 8 or 12 |
| rsp_rd | output | 1 | Read right granted |
| rsp_wr | output | 1 | Write right granted |
| rsp_ex | output | 1 | Execute right granted |
| fault_stat | output | 8 | Fault status word |
| fault_addr | output | AW | Fault address register |

## Verification
Two events can fall in the same cycle: a new fault being logged and software's read-clear of the status word. The bench provokes this by raising the read strobe in the same request cycle as a faulting access. It then judges that the following status word holds the new fault's fields, including overflow if the old word was nonzero, rather than zero. A read strobe alongside a non-faulting or no-fault-suppressed access is also driven, and there the status must clear.

// File: rtl/access_guard.sv
module access_guard #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    perm,
  input  logic          acc_write,
  input  logic          acc_fetch,
  input  logic          acc_super,
  input  logic          pg_modified,
  input  logic          nofault_en,
  input  logic [AW-1:0] vaddr,
  input  logic          stat_rd,
  output logic          rsp_valid,
  output logic          rsp_fault,
  output logic [3:0]    rsp_code,
  output logic          rsp_rd,
  output logic          rsp_wr,
  output logic          rsp_ex,
  output logic [7:0]    fault_stat,
  output logic [AW-1:0] fault_addr
);

  localparam logic [3:0] CODE_PROT = 4'd8;
  localparam logic [3:0] CODE_PRIV = 4'd12;

  logic [2:0] acc_idx;
  logic       priv_hit, prot_hit, take_fault;
  logic [3:0] code;
  logic [2:0] base_rwx, grant_rwx;
  logic [7:0] stat_next;

  assign acc_idx  = {acc_write, acc_fetch, acc_super};
  assign priv_hit = !acc_super && (perm[2:1] == 2'b11);

  always_comb begin
    unique case ({acc_write, acc_fetch})
      2'b00: prot_hit = (perm == 3'd4);
      2'b01: prot_hit = (perm == 3'd0) || (perm == 3'd1) || (perm == 3'd5);
      2'b10: prot_hit = !perm[0] || (!acc_super && perm == 3'd5);
      default: prot_hit = !(perm[1] && perm[0]);
    endcase
  end

  assign code       = priv_hit ? CODE_PRIV : (prot_hit ? CODE_PROT : 4'd0);
  assign take_fault = req_valid && (code != 4'd0) && !(nofault_en && !acc_super);

  always_comb begin
    unique case (perm)
      3'd0: base_rwx = 3'b100;
      3'd1: base_rwx = 3'b110;
      3'd2: base_rwx = 3'b101;
      3'd3: base_rwx = 3'b111;
      3'd4: base_rwx = 3'b001;
      3'd5: base_rwx = acc_super ? 3'b110 : 3'b100;
      3'd6: base_rwx = acc_super ? 3'b101 : 3'b000;
      default: base_rwx = acc_super ? 3'b111 : 3'b000;
    endcase
  end

  assign grant_rwx = take_fault ? 3'b000
                   : {base_rwx[2], base_rwx[1] & pg_modified, base_rwx[0]};

  assign stat_next = {acc_idx, 5'b0} | {4'b0, code} | 8'h02 |
                     {7'b0, (fault_stat != 8'h00)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_code   <= 4'd0;
      {rsp_rd, rsp_wr, rsp_ex} <= 3'b000;
      fault_stat <= 8'h00;
      fault_addr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= take_fault;
      rsp_code  <= take_fault ? code : 4'd0;
      {rsp_rd, rsp_wr, rsp_ex} <= req_valid ? grant_rwx : 3'b000;
      if (take_fault) begin
        fault_stat <= stat_next;
        fault_addr <= vaddr;
      end else if (stat_rd) begin
        fault_stat <= 8'h00;
      end
    end
  end

  p_fault_no_rights_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> !(rsp_rd || rsp_wr || rsp_ex));

  p_wr_needs_mod_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pg_modified) |=> !rsp_wr);

  p_user_high_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !acc_super && perm[2:1] == 2'b11) |=> !(rsp_rd || rsp_wr || rsp_ex));

  p_valid_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take_fault |=> fault_stat[1]);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_fault && fault_stat != 8'h00) |=> fault_stat[0]);

  p_nofault_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && nofault_en && !acc_super) |=> !rsp_fault);

  p_addr_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_fault |=> fault_addr == $past(vaddr));

  p_read_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !take_fault) |=> fault_stat == 8'h00);

  p_fault_beats_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && take_fault) |=> fault_stat != 8'h00);

endmodule

// File: tb/sim_access_guard.sv
module sim_access_guard;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  localparam int TBL [8][8] = '{
    '{0,0,0,0,8,0,12,12}, '{0,0,0,0,8,0,0,0},
    '{8,8,0,0,0,8,12,12}, '{8,8,0,0,0,8,0,0},
    '{8,0,8,0,8,8,12,12}, '{8,0,8,0,8,0,8,0},
    '{8,8,8,0,8,8,12,12}, '{8,8,8,0,8,8,8,0}};
  localparam logic [2:0] SUP_R [8] = '{3'b100,3'b110,3'b101,3'b111,3'b001,3'b110,3'b101,3'b111};
  localparam logic [2:0] USR_R [8] = '{3'b100,3'b110,3'b101,3'b111,3'b001,3'b100,3'b000,3'b000};

  typedef struct {
    bit          req;
    bit          flt;
    logic [3:0]  code;
    logic [2:0]  rwx;
    logic [7:0]  stat;
    logic [AW-1:0] far;
    string       tag;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, acc_write = 0, acc_fetch = 0, acc_super = 0;
  logic pg_modified = 0, nofault_en = 0, stat_rd = 0;
  logic [2:0] perm = 0;
  logic [AW-1:0] vaddr = 0;
  logic rsp_valid, rsp_fault, rsp_rd, rsp_wr, rsp_ex;
  logic [3:0] rsp_code;
  logic [7:0] fault_stat;
  logic [AW-1:0] fault_addr;

  int tests = 0, fails = 0;
  item_t q[$];
  logic [7:0] exp_stat = 0;
  logic [AW-1:0] exp_far = 0;

  access_guard #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .perm(perm),
    .acc_write(acc_write), .acc_fetch(acc_fetch), .acc_super(acc_super),
    .pg_modified(pg_modified), .nofault_en(nofault_en), .vaddr(vaddr),
    .stat_rd(stat_rd), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_code(rsp_code), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex),
    .fault_stat(fault_stat), .fault_addr(fault_addr));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic drive(input string tag, input bit req, input logic [2:0] p,
                       input bit w, input bit f, input bit s, input bit m,
                       input bit nf, input logic [AW-1:0] a, input bit rd);
    item_t it;
    logic [2:0] idx;
    int c;
    bit flt;
    @(negedge clk);
    req_valid = req; perm = p; acc_write = w; acc_fetch = f; acc_super = s;
    pg_modified = m; nofault_en = nf; vaddr = a; stat_rd = rd;
    idx = {w, f, s};
    c = TBL[idx][p];
    flt = req && (c != 0) && !(nf && !s);
    it.req = req; it.flt = flt; it.code = flt ? 4'(c) : 4'd0;
    it.rwx = s ? SUP_R[p] : USR_R[p];
    if (!m) it.rwx[1] = 1'b0;
    if (flt || !req) it.rwx = 3'b000;
    if (flt) begin
      exp_stat = (8'(idx) << 5) | 8'(c) | 8'h02 | ((exp_stat != 0) ? 8'h01 : 8'h00);
      exp_far = a;
    end else if (rd) exp_stat = 8'h00;
    it.stat = exp_stat; it.far = exp_far; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0; stat_rd = 0;
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        tests++;
        if (rsp_valid !== it.req || rsp_fault !== it.flt || rsp_code !== it.code ||
            {rsp_rd, rsp_wr, rsp_ex} !== it.rwx || fault_stat !== it.stat ||
            fault_addr !== it.far) begin
          fails++;
          $display("FAIL %s: got v=%b f=%b code=%0d rwx=%b stat=%h far=%h exp v=%b f=%b code=%0d rwx=%b stat=%h far=%h",
                   it.tag, rsp_valid, rsp_fault, rsp_code, {rsp_rd, rsp_wr, rsp_ex},
                   fault_stat, fault_addr, it.req, it.flt, it.code, it.rwx, it.stat, it.far);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stimulus
    repeat (3) @(posedge clk);
    #1;
    tests++;
    if (fault_stat !== 0 || fault_addr !== 0 || rsp_valid !== 0 || rsp_fault !== 0 ||
        rsp_code !== 0 || {rsp_rd, rsp_wr, rsp_ex} !== 0) begin
      fails++;
      $display("FAIL R11 reset: stat=%h far=%h v=%b exp all zero", fault_stat, fault_addr, rsp_valid);
    end
    @(negedge clk); rst_n = 1;

    // R2 R4 R5 R12: full table sweep, status cleared before each access
    for (int i = 0; i < 8; i++)
      for (int p = 0; p < 8; p++) begin
        drive("R2_R1_clear", 0, 0, 0, 0, 0, 1, 0, 0, 1);
        drive((i[0]) ? "R2_R4" : "R2_R5", 1, 3'(p), i[2], i[1], i[0], 1, 0,
              32'h1000_0000 + 32'(i * 64 + p * 4), 0);
      end

    // R6: write rights withheld without modified bit
    drive("R6_sup_rw", 1, 3'd1, 1, 0, 1, 0, 0, 32'hA000, 0);
    drive("R6_sup_read", 1, 3'd3, 0, 0, 1, 0, 0, 32'hA004, 0);
    drive("R6_user_read", 1, 3'd5, 0, 0, 0, 0, 0, 32'hA008, 0);

    // R3: back-to-back faults with no read in between set overflow
    drive("R9_clear", 0, 0, 0, 0, 0, 1, 0, 0, 1);
    drive("R3_first", 1, 3'd4, 0, 0, 0, 1, 0, 32'hB000, 0);
    drive("R3_overflow", 1, 3'd6, 0, 0, 0, 1, 0, 32'hB100, 0);
    drive("R8_hold", 1, 3'd3, 0, 0, 1, 1, 0, 32'hB200, 0);

    // R9: clear leaves address; R10: fault beats clear
    drive("R9_clear_keep_addr", 0, 0, 0, 0, 0, 1, 0, 0, 1);
    drive("R10_fault_and_read", 1, 3'd0, 1, 0, 1, 1, 0, 32'hC000, 1);
    drive("R10_fault_and_read_ovf", 1, 3'd7, 0, 1, 0, 1, 0, 32'hC100, 1);
    drive("R9_read_with_ok_access", 1, 3'd3, 0, 0, 0, 1, 0, 32'hC200, 1);

    // R7: no-fault mode suppresses user faults only
    drive("R7_user_priv", 1, 3'd6, 0, 0, 0, 1, 1, 32'hD000, 0);
    drive("R7_user_prot", 1, 3'd4, 0, 0, 0, 1, 1, 32'hD004, 0);
    drive("R7_user_write5", 1, 3'd5, 1, 0, 0, 1, 1, 32'hD008, 0);
    drive("R7_super_still", 1, 3'd4, 0, 0, 1, 1, 1, 32'hD00C, 0);
    drive("R7_read_clear", 1, 3'd7, 1, 0, 0, 1, 1, 32'hD010, 1);

    // R8 R12: idle cycles produce no response
    drive("R12_idle", 0, 3'd4, 0, 0, 0, 1, 0, 32'hE000, 0);
    drive("R8_last", 1, 3'd2, 1, 0, 1, 1, 0, 32'hE100, 0);
    idle();
    repeat (4) @(posedge clk);
    #1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule